// File: doc/BRIEF.md
# Bus Request and Parking Controller

This block sits at the bus edge of one agent on a shared, symmetrically arbitrated bus. It drives the agent's own active-low request line and decides, cycle by cycle, whether to raise a request, keep it, or give it up. Two internal requesters present pending transactions. An external arbiter reports when this agent owns the request phase. The other agents' request lines tell the block whether anyone else is waiting.

While the agent owns the bus, the block issues at most one start-transaction strobe per cycle. With the strobe it names the internal requester being served, and it alternates fairly between the two. Ownership is kept while a locked series is in progress, for back-to-back work when nobody else waits, or for parking when configuration allows it. Ownership is dropped in the strobe cycle when another agent is waiting. Once raised, a request is held until ownership arrives, even if the work behind it disappears. In that case the block releases without a strobe.

Top module: `breq_park_ctrl`

## Requirements
- R1: While reset is active, and after it with nothing pending, the request line is high (deasserted), the strobe is low and the grant vector is zero.
- R2: With the request line deasserted, any pending internal requester drives the line low in the same cycle.
- R3: Once the line is low and ownership is not indicated, the line stays low on the next cycle, even if every pending request has been withdrawn.
- R4: The strobe fires only in a cycle where ownership is indicated and the line was already low in the previous cycle, and at least one requester is pending. The grant vector is one-hot (bit 0 for requester 0, bit 1 for requester 1) exactly when the strobe fires, and zero otherwise.
- R5: Pending requesters are served round-robin. The requester served last has the lowest priority, and after reset requester 0 has priority.
- R6: With the lock flag low, parking disabled and no further pending work, the line goes high in the same cycle as the strobe.
- R7: With the lock flag low and no other agent requesting, the line stays low during a strobe if another requester still has work pending.
- R8: With parking enabled and no other agent requesting, an owner with nothing pending keeps the line low. It drives the line high in the first cycle another agent's line (active low) is seen low.
- R9: If another agent is requesting during a strobe and the lock flag is low, the line goes high with that strobe. If work is still pending, the line goes low again on the following cycle.
- R10: While owning with the lock flag high, the line stays low whatever the other agents request.
- R11: An owner with nothing pending, the lock flag low and parking disabled drives the line high without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pend_i | input | NUM_SRC | Pending-transaction flags, one per internal requester |
| lock_i | input | 1 | A locked transaction series is in progress |
| park_en_i | input | 1 | Configuration: parking on this agent allowed |
| own_i | input | 1 | Arbiter indicates this agent owns the request phase |
| peer_req_n_i | input | NUM_PEER | Other agents' request lines, active low |
| breq_n_o | output | 1 | This agent's request line, active low |
| start_o | output | 1 | Start-transaction strobe |
| gnt_o | output | NUM_SRC | One-hot grant naming the requester served by the strobe |

## Verification
A wrong line register shows up at the request pin at once. The pin either fails to hold through a cancelled request or asserts late, and the very next owned cycle then has a missing or unexpected strobe. A corrupted round-robin pointer shows only when both requesters are pending at a strobe: the grant names the wrong requester in that same cycle. Errors in the keep/release decision appear on the request pin within the strobe cycle, so each scenario is compared every cycle rather than only at the end.

// File: rtl/brp_pkg.sv
package brp_pkg;
  // State of this agent's own request line as held in the register
  typedef enum logic {
    LINE_IDLE = 1'b0,
    LINE_HELD = 1'b1
  } line_e;
endpackage

// File: rtl/brp_rr_sel.sv
module brp_rr_sel #(
  parameter int NUM_SRC = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               adv_i,
  output logic [NUM_SRC-1:0] pick_o
);
  localparam int IDXW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [IDXW-1:0] last_q;
  logic [IDXW-1:0] last_d;
  logic [IDXW-1:0] sel;
  logic            found;

  // next-state: first pending source after the one served last
  always_comb begin
    pick_o = '0;
    last_d = last_q;
    found  = 1'b0;
    sel    = '0;
    for (int k = 0; k < NUM_SRC; k++) begin
      sel = IDXW'((int'(last_q) + 1 + k) % NUM_SRC);
      if (!found && req_i[sel]) begin
        pick_o[sel] = 1'b1;
        last_d      = sel;
        found       = 1'b1;
      end
    end
  end

  // register with explicit enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= IDXW'(NUM_SRC - 1);
    end else if (adv_i) begin
      last_q <= last_d;
    end
  end

  // R4
  pick_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pick_o));

  generate
    if (NUM_SRC == 2) begin : g_pair
      // R5
      rr_alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && pick_o[0]) |=> (!(adv_i && req_i[1]) || pick_o[1]));
    end
  endgenerate
endmodule

// File: rtl/brp_line_ctl.sv
module brp_line_ctl
  import brp_pkg::*;
#(
  parameter int NUM_PEER = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                any_pend_i,
  input  logic                more_pend_i,
  input  logic                lock_i,
  input  logic                park_en_i,
  input  logic                own_i,
  input  logic [NUM_PEER-1:0] peer_req_n_i,
  output logic                line_o,
  output logic                owned_o
);
  line_e req_q;
  logic  line_d;
  logic  peer_wait;
  logic  keep;

  assign peer_wait = |(~peer_req_n_i);
  assign owned_o   = (req_q == LINE_HELD) && own_i;

  // next-state: keep for lock, back-to-back work or parking, else release
  always_comb begin
    keep = lock_i | (!peer_wait & (park_en_i | more_pend_i));
    if (req_q == LINE_IDLE) begin
      line_d = any_pend_i;
    end else if (!own_i) begin
      line_d = 1'b1;
    end else begin
      line_d = keep;
    end
  end

  assign line_o = line_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= LINE_IDLE;
    end else begin
      req_q <= line_e'(line_d);
    end
  end

  // R3
  hold_until_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_o && !own_i) |=> (line_o || own_i));

  // R10
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owned_o && lock_i) |-> line_o);

  // R8
  park_yield_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owned_o && !lock_i && !any_pend_i && peer_wait) |-> !line_o);
endmodule

// File: rtl/breq_park_ctrl.sv
module breq_park_ctrl #(
  parameter int NUM_SRC  = 2,
  parameter int NUM_PEER = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SRC-1:0]  pend_i,
  input  logic                lock_i,
  input  logic                park_en_i,
  input  logic                own_i,
  input  logic [NUM_PEER-1:0] peer_req_n_i,
  output logic                breq_n_o,
  output logic                start_o,
  output logic [NUM_SRC-1:0]  gnt_o
);
  logic [1:0]         rst_sync_q;
  logic               rst_n_int;
  logic [NUM_SRC-1:0] pick;
  logic               owned;
  logic               line;
  logic               any_pend;
  logic               more_pend;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_int = rst_sync_q[1];

  assign any_pend  = |pend_i;
  assign more_pend = |(pend_i & ~pick);
  assign start_o   = owned & any_pend;
  assign gnt_o     = owned ? pick : '0;
  assign breq_n_o  = ~line;

  brp_rr_sel #(.NUM_SRC(NUM_SRC)) u_rr (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .req_i  (pend_i),
    .adv_i  (start_o),
    .pick_o (pick)
  );

  brp_line_ctl #(.NUM_PEER(NUM_PEER)) u_line (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .any_pend_i   (any_pend),
    .more_pend_i  (more_pend),
    .lock_i       (lock_i),
    .park_en_i    (park_en_i),
    .own_i        (own_i),
    .peer_req_n_i (peer_req_n_i),
    .line_o       (line),
    .owned_o      (owned)
  );

  // R4
  strobe_needs_own_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    start_o |-> own_i);

  // R4
  strobe_names_src_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    start_o == (|gnt_o));

  // R9
  polite_release_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (start_o && !lock_i && (peer_req_n_i != '1)) |-> breq_n_o);

  // R7
  back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (start_o && !lock_i && (peer_req_n_i == '1) && (|(pend_i & ~gnt_o))) |-> !breq_n_o);
endmodule

// File: tb/breq_park_ctrl_tb_top.sv
`timescale 1ns/100ps
module breq_park_ctrl_tb_top;
  logic       clk;
  logic       rst_n;
  logic [1:0] pend;
  logic       lock;
  logic       park;
  logic       own;
  logic [2:0] peer_n;
  logic       breq_n;
  logic       start;
  logic [1:0] gnt;

  typedef struct packed {
    logic       bn;
    logic       st;
    logic [1:0] g;
    logic [7:0] rid;
  } exp_t;

  exp_t q[$];
  int   n_cmp;
  int   n_bad;
  bit   done;

  breq_park_ctrl #(.NUM_SRC(2), .NUM_PEER(3)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .pend_i       (pend),
    .lock_i       (lock),
    .park_en_i    (park),
    .own_i        (own),
    .peer_req_n_i (peer_n),
    .breq_n_o     (breq_n),
    .start_o      (start),
    .gnt_o        (gnt)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // driver: apply one cycle of stimulus and queue what the requirements predict
  task automatic step(input logic [1:0] p, input logic lk, input logic pk,
                      input logic ow, input logic [2:0] pr,
                      input logic ebn, input logic est, input logic [1:0] eg,
                      input int rid);
    exp_t e;
    @(posedge clk);
    #1;
    pend = p; lock = lk; park = pk; own = ow; peer_n = pr;
    e.bn = ebn; e.st = est; e.g = eg; e.rid = 8'(rid);
    q.push_back(e);
  endtask

  // monitor: compare in the middle of the cycle
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_cmp++;
      if (breq_n !== e.bn || start !== e.st || gnt !== e.g) begin
        n_bad++;
        $display("FAIL R%0d: got breq_n=%b start=%b gnt=%b, want breq_n=%b start=%b gnt=%b",
                 e.rid, breq_n, start, gnt, e.bn, e.st, e.g);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang, want completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    n_cmp = 0; n_bad = 0; done = 0;
    rst_n = 1'b0; pend = '0; lock = 0; park = 0; own = 0; peer_n = 3'b111;
    // R1 reset state
    step(2'b00,0,0,0,3'b111, 1,0,2'b00, 1);
    step(2'b00,0,0,0,3'b111, 1,0,2'b00, 1);
    rst_n = 1'b1;
    step(2'b00,0,0,0,3'b111, 1,0,2'b00, 1);
    step(2'b00,0,0,0,3'b111, 1,0,2'b00, 1);
    step(2'b00,0,0,0,3'b111, 1,0,2'b00, 1);
    // R2 immediate request, R3 hold, R7 keep for more work, R6 release
    step(2'b11,0,0,0,3'b111, 0,0,2'b00, 2);
    step(2'b11,0,0,0,3'b111, 0,0,2'b00, 3);
    step(2'b11,0,0,1,3'b111, 0,1,2'b01, 7);  // R5 requester 0 first
    step(2'b10,0,0,1,3'b111, 1,1,2'b10, 6);
    step(2'b00,0,0,0,3'b111, 1,0,2'b00, 6);
    // R5 alternation with both pending
    step(2'b11,0,0,0,3'b111, 0,0,2'b00, 2);
    step(2'b11,0,0,1,3'b111, 0,1,2'b01, 5);
    step(2'b11,0,0,1,3'b111, 0,1,2'b10, 5);
    step(2'b01,0,0,1,3'b111, 1,1,2'b01, 6);
    step(2'b00,0,0,0,3'b111, 1,0,2'b00, 6);
    // R3 cancelled while waiting, R11 release without strobe
    step(2'b01,0,0,0,3'b111, 0,0,2'b00, 2);
    step(2'b00,0,0,0,3'b111, 0,0,2'b00, 3);
    step(2'b00,0,0,1,3'b111, 1,0,2'b00, 11);
    step(2'b00,0,0,0,3'b111, 1,0,2'b00, 11);
    // R8 parking, then yield to a peer
    step(2'b01,0,1,0,3'b111, 0,0,2'b00, 2);
    step(2'b01,0,1,1,3'b111, 0,1,2'b01, 8);
    step(2'b00,0,1,1,3'b111, 0,0,2'b00, 8);
    step(2'b00,0,1,1,3'b110, 1,0,2'b00, 8);
    step(2'b00,0,1,0,3'b110, 1,0,2'b00, 8);
    // R9 polite release and reassert
    step(2'b11,0,0,0,3'b110, 0,0,2'b00, 2);
    step(2'b11,0,0,1,3'b110, 1,1,2'b10, 9);
    step(2'b01,0,0,0,3'b110, 0,0,2'b00, 9);
    step(2'b01,0,0,1,3'b110, 1,1,2'b01, 9);
    step(2'b00,0,0,0,3'b111, 1,0,2'b00, 9);
    // R10 lock overrides a waiting peer
    step(2'b01,1,0,0,3'b110, 0,0,2'b00, 2);
    step(2'b01,1,0,1,3'b110, 0,1,2'b01, 10);
    step(2'b00,1,0,1,3'b110, 0,0,2'b00, 10);
    step(2'b00,0,0,1,3'b110, 1,0,2'b00, 10);
    step(2'b00,0,0,0,3'b111, 1,0,2'b00, 10);
    // R4 ownership seen before own request registered gives no strobe
    step(2'b01,0,0,1,3'b111, 0,0,2'b00, 4);
    step(2'b01,0,0,1,3'b111, 1,1,2'b01, 4);
    step(2'b00,0,0,0,3'b111, 1,0,2'b00, 4);
    repeat (3) @(posedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule